// File: doc/BRIEF.md
# Key-Value Command Stream Receiver

This block terminates a two-lane transfer. The command lane carries commands of two beats each: a key beat, then a value beat. The value beat holds a chaining bit that says whether another command follows. The data lane runs alongside at the same time and carries words that are qualified one by one. The receiver keeps the most recent value for each key in a table indexed by key. Data words go into a buffer in arrival order. The block raises a one-cycle done pulse once both lanes have finished.

Each command beat arrives with a kind bit (0 = key beat, 1 = value beat) and a flag bit. On a key beat the flag means "key valid". On a value beat it means "more commands follow". Protocol faults and length overruns set sticky error flags that stay set for the rest of the frame. After done, the next valid key beat or data word opens a new frame. The table, the counts and the error flags are cleared, and that beat is taken as the first item of the new frame. The host reads results combinationally: it drives a key for the table, or a word index for the buffer.

Top module: `kv_cmd_rx`

## Requirements
- R1: After reset, cmd_cnt_o and word_cnt_o are 0, done_o is 0, all three error flags are 0, and rd_hit_o is 0 for every key.
- R2: A key beat (kind 0) with flag 1, then a value beat (kind 1), stores the value under the key held in the low KEY_W bits of the key byte. From the next cycle, rd_hit_o is 1 and rd_val_o returns that value, and cmd_cnt_o has increased by one.
- R3: A key beat with flag 0 is an idle cycle and stores no key. A value beat that follows it is handled as if no key were pending.
- R4: A value beat with no pending key sets err_proto_o and stores nothing. The one exception is the empty-list case of R6. A key beat that arrives while a value is pending also sets err_proto_o and is discarded, and the pending key is kept.
- R5: A command whose key repeats an earlier key in the same frame replaces the stored value, and it still counts in cmd_cnt_o.
- R6: A value beat with flag 0 ends the command list. A value beat with flag 0 that arrives while waiting for a key, with no command yet in the frame, ends an empty list without an error. Command beats that arrive after the list has ended and before done are ignored.
- R7: A command beyond MAX_CMDS is discarded and sets err_cmd_ovf_o. cmd_cnt_o stays at MAX_CMDS, and the flag of that command's value beat still decides whether the list ends.
- R8: Each cycle with dat_vld_i high stores dat_byte_i at index word_cnt_o and increments word_cnt_o. Cycles with dat_vld_i low store nothing.
- R9: A data word beyond MAX_WORDS is discarded and sets err_dat_ovf_o, and word_cnt_o stays at MAX_WORDS.
- R10: dat_last_i ends the data lane. The word in that cycle is included if dat_vld_i is high. With dat_vld_i low it ends an empty lane. Later words are ignored until the next frame.
- R11: done_o is high for exactly one cycle, the cycle after the later of the two lane ends is taken.
- R12: After done, a key beat with flag 1 or a data word starts a new frame. The table is cleared, the counts restart from 0, and all error flags clear. That beat is processed as the first of the new frame.
- R13: The two lanes are independent. A command beat and a data word in the same cycle are both processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_beat_i | input | 1 | Command beat present |
| cmd_kind_i | input | 1 | 0 = key beat, 1 = value beat |
| cmd_flag_i | input | 1 | Key valid (key beat) or more follows (value beat) |
| cmd_byte_i | input | CMD_W | Key (low KEY_W bits) or value |
| dat_vld_i | input | 1 | Data word present |
| dat_last_i | input | 1 | End of data lane |
| dat_byte_i | input | DAT_W | Data word |
| rd_key_i | input | KEY_W | Table read key |
| rd_hit_o | output | 1 | Key is stored in the current frame |
| rd_val_o | output | CMD_W | Stored value for rd_key_i |
| rd_idx_i | input | IDX_W | Buffer read index |
| rd_word_o | output | DAT_W | Buffered word at rd_idx_i |
| cmd_cnt_o | output | CNT_W | Commands stored this frame |
| word_cnt_o | output | WCNT_W | Words stored this frame |
| done_o | output | 1 | One-cycle pulse when both lanes have ended |
| err_proto_o | output | 1 | Sticky: beat out of order on the command lane |
| err_cmd_ovf_o | output | 1 | Sticky: too many commands |
| err_dat_ovf_o | output | 1 | Sticky: too many data words |

## Verification
The bench builds the block with a 3-bit key, MAX_CMDS of 4 and MAX_WORDS of 5. This keeps both overflow limits only a few beats away. The bench sweeps every command count from 0 to 6 against every word count from 0 to 7, with both lanes running at the same time. That sweep covers empty lists, exact-limit lists and over-limit lists on both lanes, and it checks the done cycle each time. The 8-entry key space lets the bench check every table slot for hits. Directed frames then cover idle keys, orphan and double key beats, overwrites, traffic after a lane has ended, and the start of a new frame after done.

// File: rtl/kv_rx_pkg.sv
package kv_rx_pkg;
  typedef enum logic [1:0] {ST_KEY, ST_VAL, ST_END} cmd_st_e;
  localparam logic KIND_KEY = 1'b0;
  localparam logic KIND_VAL = 1'b1;
endpackage

// File: rtl/kv_cmd_ctrl.sv
module kv_cmd_ctrl
  import kv_rx_pkg::*;
#(
  parameter int KEY_W    = 8,
  parameter int CMD_W    = 8,
  parameter int MAX_CMDS = 64,
  localparam int CNT_W   = $clog2(MAX_CMDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic             kind_i,
  input  logic             flag_i,
  input  logic [CMD_W-1:0] byte_i,
  output logic             wr_en_o,
  output logic [KEY_W-1:0] wr_key_o,
  output logic [CMD_W-1:0] wr_val_o,
  output logic             ended_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_proto_o,
  output logic             err_ovf_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CMDS);

  cmd_st_e          st_q, st_d, st_eff;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic [KEY_W-1:0] key_q, key_d;
  logic             proto_q, proto_d, ovf_q, ovf_d;

  always_comb begin
    // a frame start rewinds the lane before the current beat is taken
    st_eff  = start_i ? ST_KEY : st_q;
    cnt_eff = start_i ? '0 : cnt_q;
    st_d    = st_eff;
    cnt_d   = cnt_eff;
    key_d   = key_q;
    proto_d = proto_q & ~start_i;
    ovf_d   = ovf_q & ~start_i;
    wr_en_o = 1'b0;
    if (beat_i) begin
      unique case (st_eff)
        ST_KEY: begin
          if (kind_i == KIND_KEY) begin
            if (flag_i) begin
              key_d = byte_i[KEY_W-1:0];
              st_d  = ST_VAL;
            end
          end else if (!flag_i && cnt_eff == '0) begin
            st_d = ST_END;
          end else begin
            proto_d = 1'b1;
          end
        end
        ST_VAL: begin
          if (kind_i == KIND_VAL) begin
            if (cnt_eff < MAX_C) begin
              wr_en_o = 1'b1;
              cnt_d   = cnt_eff + 1'b1;
            end else begin
              ovf_d = 1'b1;
            end
            st_d = flag_i ? ST_KEY : ST_END;
          end else begin
            proto_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_KEY;
      cnt_q   <= '0;
      key_q   <= '0;
      proto_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      key_q   <= key_d;
      proto_q <= proto_d;
      ovf_q   <= ovf_d;
    end
  end

  assign wr_key_o    = key_q;
  assign wr_val_o    = byte_i;
  assign ended_o     = (st_q == ST_END);
  assign cnt_o       = cnt_q;
  assign err_proto_o = proto_q;
  assign err_ovf_o   = ovf_q;

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  a_r6_end_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_END && !start_i) |=> (st_q == ST_END && $stable(cnt_q)));
  a_r4_orphan_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && kind_i == KIND_VAL && st_q == ST_KEY && !start_i && cnt_q != '0)
      |=> (proto_q && $stable(cnt_q)));
endmodule

// File: rtl/kv_pair_table.sv
module kv_pair_table #(
  parameter int KEY_W   = 8,
  parameter int VAL_W   = 8,
  localparam int TBL_N  = 1 << KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic [KEY_W-1:0] rd_key_i,
  output logic             rd_hit_o,
  output logic [VAL_W-1:0] rd_val_o
);
  logic [TBL_N-1:0] vld_q;
  logic [VAL_W-1:0] val_q [TBL_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (clr_i)   vld_q <= '0;
      if (wr_en_i) vld_q[wr_key_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) val_q[wr_key_i] <= wr_val_i;
  end

  assign rd_hit_o = vld_q[rd_key_i];
  assign rd_val_o = val_q[rd_key_i];

  a_r2_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_key_i)]);
  a_r12_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_en_i) |=> (vld_q == '0));
endmodule

// File: rtl/kv_word_buf.sv
module kv_word_buf #(
  parameter int DAT_W     = 8,
  parameter int MAX_WORDS = 128,
  localparam int WCNT_W   = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS),
  localparam int MEM_N    = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic [DAT_W-1:0]  byte_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DAT_W-1:0]  rd_word_o,
  output logic [WCNT_W-1:0] cnt_o,
  output logic              ended_o,
  output logic              err_ovf_o
);
  localparam logic [WCNT_W-1:0] MAX_C = WCNT_W'(MAX_WORDS);

  logic [WCNT_W-1:0] cnt_q, cnt_eff;
  logic              end_q, end_eff, ovf_q, ovf_eff;
  logic              take;
  logic [DAT_W-1:0]  mem_q [MEM_N];

  assign cnt_eff = start_i ? '0 : cnt_q;
  assign end_eff = end_q & ~start_i;
  assign ovf_eff = ovf_q & ~start_i;
  assign take    = vld_i & ~end_eff & (cnt_eff < MAX_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      end_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= take ? cnt_eff + 1'b1 : cnt_eff;
      end_q <= end_eff | last_i;
      ovf_q <= ovf_eff | (vld_i & ~end_eff & ~take);
    end
  end

  always_ff @(posedge clk_i) begin
    if (take) mem_q[cnt_eff[IDX_W-1:0]] <= byte_i;
  end

  assign rd_word_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign ended_o   = end_q;
  assign err_ovf_o = ovf_q;

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  a_r10_end_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_q && !start_i) |=> (end_q && $stable(cnt_q)));
endmodule

// File: rtl/kv_cmd_rx.sv
module kv_cmd_rx #(
  parameter int KEY_W     = 8,
  parameter int CMD_W     = 8,
  parameter int DAT_W     = 8,
  parameter int MAX_CMDS  = 64,
  parameter int MAX_WORDS = 128,
  localparam int CNT_W    = $clog2(MAX_CMDS + 1),
  localparam int WCNT_W   = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_beat_i,
  input  logic              cmd_kind_i,
  input  logic              cmd_flag_i,
  input  logic [CMD_W-1:0]  cmd_byte_i,
  input  logic              dat_vld_i,
  input  logic              dat_last_i,
  input  logic [DAT_W-1:0]  dat_byte_i,
  input  logic [KEY_W-1:0]  rd_key_i,
  output logic              rd_hit_o,
  output logic [CMD_W-1:0]  rd_val_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DAT_W-1:0]  rd_word_o,
  output logic [CNT_W-1:0]  cmd_cnt_o,
  output logic [WCNT_W-1:0] word_cnt_o,
  output logic              done_o,
  output logic              err_proto_o,
  output logic              err_cmd_ovf_o,
  output logic              err_dat_ovf_o
);
  logic             start, closed_q, cmd_end, dat_end;
  logic             wr_en;
  logic [KEY_W-1:0] wr_key;
  logic [CMD_W-1:0] wr_val;

  // a frame opens again only on a beat that carries content
  assign start  = closed_q & ((cmd_beat_i & ~cmd_kind_i & cmd_flag_i) | dat_vld_i);
  assign done_o = cmd_end & dat_end & ~closed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) closed_q <= 1'b0;
    else         closed_q <= ~start & (closed_q | done_o);
  end

  kv_cmd_ctrl #(.KEY_W(KEY_W), .CMD_W(CMD_W), .MAX_CMDS(MAX_CMDS)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i     (start),
    .beat_i      (cmd_beat_i),
    .kind_i      (cmd_kind_i),
    .flag_i      (cmd_flag_i),
    .byte_i      (cmd_byte_i),
    .wr_en_o     (wr_en),
    .wr_key_o    (wr_key),
    .wr_val_o    (wr_val),
    .ended_o     (cmd_end),
    .cnt_o       (cmd_cnt_o),
    .err_proto_o (err_proto_o),
    .err_ovf_o   (err_cmd_ovf_o)
  );

  kv_pair_table #(.KEY_W(KEY_W), .VAL_W(CMD_W)) u_table (
    .clk_i, .rst_ni,
    .clr_i    (start),
    .wr_en_i  (wr_en),
    .wr_key_i (wr_key),
    .wr_val_i (wr_val),
    .rd_key_i (rd_key_i),
    .rd_hit_o (rd_hit_o),
    .rd_val_o (rd_val_o)
  );

  kv_word_buf #(.DAT_W(DAT_W), .MAX_WORDS(MAX_WORDS)) u_buf (
    .clk_i, .rst_ni,
    .start_i   (start),
    .vld_i     (dat_vld_i),
    .last_i    (dat_last_i),
    .byte_i    (dat_byte_i),
    .rd_idx_i  (rd_idx_i),
    .rd_word_o (rd_word_o),
    .cnt_o     (word_cnt_o),
    .ended_o   (dat_end),
    .err_ovf_o (err_dat_ovf_o)
  );

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_closed_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start) |=> closed_q);
endmodule

// File: tb/sim_kv_cmd_rx.sv
`timescale 1ns/1ps
module sim_kv_cmd_rx;
  localparam int KW = 3, MC = 4, MW = 5;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       cb = 0, ck = 0, cf = 0, dv = 0, dl = 0;
  logic [7:0] cbyte = 0, db = 0;
  logic [2:0] rkey = 0, ridx = 0;
  logic       hit, done, ep, eco, edo;
  logic [7:0] rval, rword;
  logic [2:0] ccnt, wcnt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  kv_cmd_rx #(.KEY_W(KW), .CMD_W(8), .DAT_W(8), .MAX_CMDS(MC), .MAX_WORDS(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_beat_i(cb), .cmd_kind_i(ck), .cmd_flag_i(cf), .cmd_byte_i(cbyte),
    .dat_vld_i(dv), .dat_last_i(dl), .dat_byte_i(db),
    .rd_key_i(rkey), .rd_hit_o(hit), .rd_val_o(rval),
    .rd_idx_i(ridx), .rd_word_o(rword),
    .cmd_cnt_o(ccnt), .word_cnt_o(wcnt), .done_o(done),
    .err_proto_o(ep), .err_cmd_ovf_o(eco), .err_dat_ovf_o(edo)
  );

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic cyc(input logic b, k, f, input logic [7:0] cy,
                     input logic v, l, input logic [7:0] d);
    cb = b; ck = k; cf = f; cbyte = cy; dv = v; dl = l; db = d;
    @(negedge clk);
    cb = 0; ck = 0; cf = 0; cbyte = 0; dv = 0; dl = 0; db = 0;
  endtask

  task automatic cmd(input logic k, f, input logic [7:0] cy);
    cyc(1'b1, k, f, cy, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic look(input logic [2:0] k, input string r, input int eh, input int ev);
    rkey = k; #1;
    chk(r, int'(hit), eh);
    if (eh == 1) chk(r, int'(rval), ev);
  endtask

  task automatic word_at(input logic [2:0] i, input string r, input int ev);
    ridx = i; #1;
    chk(r, int'(rword), ev);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cmd_cnt", ccnt, 0); chk("R1 word_cnt", wcnt, 0);
    chk("R1 done", done, 0);
    chk("R1 errs", {ep, eco, edo}, 0);
    for (int k = 0; k < 8; k++) look(3'(k), "R1 no hit", 0, 0);

    // R13 sweep: n commands and m words concurrently; R2 R6 R7 R8 R9 R10 R11
    for (int n = 0; n <= MC + 2; n++) begin
      for (int m = 0; m <= MW + 2; m++) begin
        int ce, de, te;
        do_reset();
        ce = (n > 0) ? 2 * n - 1 : 0;
        de = (m > 0) ? m - 1 : 0;
        te = (ce > de) ? ce : de;
        for (int t = 0; t <= te + 2; t++) begin
          logic b, k, f, v, l;
          logic [7:0] cy, d;
          b = 0; k = 0; f = 0; cy = 0; v = 0; l = 0; d = 0;
          if (n == 0 && t == 0) begin b = 1; k = 1; f = 0; cy = 8'hEE; end
          else if (t < 2 * n) begin
            b = 1; k = t[0];
            if (!k) begin f = 1; cy = 8'((3 * (t / 2) + 1) % 8); end
            else begin f = (t / 2) < n - 1; cy = 8'((t / 2) * 17 + 5); end
          end
          if (t < m) begin v = 1; d = 8'(8'hA0 + t); l = (t == m - 1); end
          else if (m == 0 && t == 0) l = 1;
          cyc(b, k, f, cy, v, l, d);
          chk("R11 done timing", done, (t == te) ? 1 : 0);
        end
        chk("R7 cmd_cnt", ccnt, (n > MC) ? MC : n);
        chk("R7 cmd ovf", eco, (n > MC) ? 1 : 0);
        chk("R6 no proto err", ep, 0);
        for (int i = 0; i < n; i++)
          look(3'((3 * i + 1) % 8), "R2 table", (i < MC) ? 1 : 0, (i * 17 + 5) % 256);
        chk("R9 word_cnt", wcnt, (m > MW) ? MW : m);
        chk("R9 dat ovf", edo, (m > MW) ? 1 : 0);
        for (int j = 0; j < m && j < MW; j++) word_at(3'(j), "R8 word", 8'hA0 + j);
      end
    end

    // R3 idle key then value beat is an orphan
    do_reset();
    cmd(0, 0, 8'h02);
    cmd(1, 1, 8'h77);
    chk("R3 idle key then value", ep, 1);
    chk("R3 cnt", ccnt, 0);
    look(3'd2, "R3 no store", 0, 0);

    // R4 second key while value pending is discarded
    do_reset();
    cmd(0, 1, 8'h02);
    cmd(0, 1, 8'h05);
    chk("R4 double key err", ep, 1);
    cmd(1, 1, 8'h33);
    look(3'd2, "R4 pending key kept", 1, 8'h33);
    look(3'd5, "R4 extra key dropped", 0, 0);
    cmd(0, 1, 8'h07);
    cmd(1, 0, 8'h44);
    chk("R4 cnt", ccnt, 2);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R11 done", done, 1);
    @(negedge clk);
    chk("R11 done once", done, 0);
    // R12 data word opens a new frame
    cyc(0, 0, 0, 0, 1, 0, 8'h9C);
    chk("R12 err cleared", ep, 0);
    chk("R12 cmd_cnt reset", ccnt, 0);
    chk("R12 word_cnt", wcnt, 1);
    word_at(3'd0, "R12 first word", 8'h9C);
    look(3'd2, "R12 table cleared", 0, 0);
    cmd(0, 1, 8'h01);
    cmd(1, 0, 8'h55);
    look(3'd1, "R12 new pair", 1, 8'h55);

    // R5 overwrite, then R6 beats after list end ignored
    do_reset();
    cmd(0, 1, 8'h03); cmd(1, 1, 8'h11);
    cmd(0, 1, 8'h03); cmd(1, 0, 8'h22);
    chk("R5 cnt counts both", ccnt, 2);
    look(3'd3, "R5 overwrite", 1, 8'h22);
    cmd(0, 1, 8'h06); cmd(1, 0, 8'h44);
    chk("R6 ignored after end", ccnt, 2);
    look(3'd6, "R6 no store", 0, 0);
    chk("R6 no error", ep, 0);

    // R8 gaps, R10 words after last ignored
    do_reset();
    cyc(0, 0, 0, 0, 1, 0, 8'h11);
    cyc(0, 0, 0, 0, 0, 0, 8'hFF);
    cyc(0, 0, 0, 0, 1, 0, 8'h22);
    cyc(0, 0, 0, 0, 1, 1, 8'h33);
    cyc(0, 0, 0, 0, 1, 0, 8'h44);
    chk("R10 cnt after last", wcnt, 3);
    word_at(3'd0, "R8 w0", 8'h11);
    word_at(3'd1, "R8 w1", 8'h22);
    word_at(3'd2, "R10 w2", 8'h33);
    chk("R10 no done before cmd end", done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule